// File: doc/BRIEF.md
# Switched-Parameter Chaotic Map Random Bit Generator

This block produces a pseudo-random bit stream by iterating a discretised multiply-and-wrap chaotic map on an n-bit fixed-point fraction. In each step the state k is multiplied by a fixed-point factor β, which has n integer bits and n fraction bits. The integer part of the product, taken modulo 2^n, becomes the new state. The exported random bit is the top bit of that state.

β is not a single constant. On every step it is one of four near-identical values, and the choice comes from a 2-bit code taken from a small 5-bit linear feedback shift register. The four values differ only in the three top integer bits, and their fraction bits are all ones. Switching the factor this way lengthens the cycle of the map and hides which factor is in use.

Control is a two-state machine. After reset the machine is in UNSEEDED, where step requests are ignored. A seed load moves it to RUN (transition UNSEEDED→RUN on load). In RUN, a step request advances the map and the code register. A further seed load restarts both (RUN→RUN on load), and a synchronous reset returns the machine to UNSEEDED from either state.

Top module: `chaos_rng_top`

## Requirements
- R1: During a cycle with reset high, the next edge clears the state to zero and puts the machine in UNSEEDED. The output bit then reads 0 and the code register holds 5'b00001.
- R2: In UNSEEDED, a step request has no effect: the state stays at zero until a seed is loaded.
- R3: A seed load takes the seed value into the state at the next edge and restarts the code register at 5'b00001. A seed of zero is stored as 1. A seed load wins over a step request in the same cycle.
- R4: In RUN, a step request without a seed load replaces the state k by floor(β·k / 2^n) mod 2^n. Here β = H·2^(2n−3) + (2^n − 1), where H is the 3-bit head chosen by the current code.
- R5: The code is bits [1:0] of the code register before the step. It maps to H as follows: 00→3'b111, 01→3'b011, 10→3'b110, 11→3'b010.
- R6: The code register shifts left by one on each taken step, inserting bit4 XOR bit2 at bit0. From any nonzero value it visits all 31 nonzero values and never reaches zero.
- R7: The random bit output always equals bit n−1 of the state output.
- R8: In RUN, with no step request and no seed load, the state and the code register hold. A later step therefore uses the code that was pending before the pause.
- R9: Both datapath variants compute the same next state for every state and code. One variant is the full 2n-by-n product. The other is a reduced form that uses k−1 plus a shifted 3-bit term.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load seed_val into the state and restart the code register |
| seed_val | input | STATE_W | Seed value, where zero is stored as 1 |
| step_en | input | 1 | Request one map step |
| rnd_bit | output | 1 | Random bit: top bit of the current state |
| state_out | output | STATE_W | Current map state |

## Verification
The bench builds two instances on the same controls. The first uses a 32-bit state and the reduced shift-and-add datapath. The second uses a 12-bit state and the full multiplier. Comparing both against one arbitrary-width model covers the R9 equivalence. The narrow instance also wraps often enough to hit states near zero and all ones. Long stretches of steps take the code register through its full 31-value cycle many times, so every head is used from many different states.

// File: rtl/chaos_rng_pkg.sv
package chaos_rng_pkg;

    localparam int CODE_REG_W = 5;
    localparam int SEL_W      = 2;
    localparam int HEAD_W     = 3;
    localparam logic [CODE_REG_W-1:0] CODE_REG_INIT = 5'b00001;

    typedef enum logic [0:0] {
        ST_UNSEEDED = 1'b0,
        ST_RUN      = 1'b1
    } rng_fsm_e;

    typedef logic [SEL_W-1:0]  sel_code_t;
    typedef logic [HEAD_W-1:0] beta_head_t;

endpackage

// File: rtl/chaos_code_lfsr.sv
module chaos_code_lfsr
    import chaos_rng_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  restart,
    input  logic                  advance,
    output sel_code_t             code,
    output logic [CODE_REG_W-1:0] reg_q
);

    logic [CODE_REG_W-1:0] q_r;
    logic                  fb;

    // Feedback taps follow x^5 + x^3 + 1.
    assign fb = q_r[4] ^ q_r[2];

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            q_r <= CODE_REG_INIT;
        end else if (advance) begin
            q_r <= {q_r[CODE_REG_W-2:0], fb};
        end
    end

    assign code  = q_r[SEL_W-1:0];
    assign reg_q = q_r;

    p_never_zero_r6: assert property (@(posedge clk) disable iff (rst)
        q_r != '0);

    p_moves_on_step_r6: assert property (@(posedge clk) disable iff (rst)
        (advance && !restart) |=> (q_r != $past(q_r)));

    p_restart_value_r3: assert property (@(posedge clk) disable iff (rst)
        restart |=> (q_r == CODE_REG_INIT));

endmodule

// File: rtl/chaos_head_dec.sv
module chaos_head_dec
    import chaos_rng_pkg::*;
(
    input  sel_code_t  code,
    output beta_head_t head
);

    always_comb begin
        unique case (code)
            2'b00:   head = 3'b111;
            2'b01:   head = 3'b011;
            2'b10:   head = 3'b110;
            default: head = 3'b010;
        endcase
    end

    // R5: all heads share the middle bit, so they differ in at most two positions.
    always_comb begin
        if (!$isunknown(code)) begin
            p_head_shared_bit_r5: assert (head[1] == 1'b1);
        end
    end

endmodule

// File: rtl/chaos_map_step.sv
module chaos_map_step
    import chaos_rng_pkg::*;
#(
    parameter int STATE_W      = 32,
    parameter bit FULL_PRODUCT = 1'b0
) (
    input  logic [STATE_W-1:0] k_cur,
    input  beta_head_t         head,
    output logic [STATE_W-1:0] k_next
);

    localparam int SHIFT_W = STATE_W - HEAD_W;
    localparam int BETA_W  = 2 * STATE_W;
    localparam int PROD_W  = 3 * STATE_W;

    generate
        if (FULL_PRODUCT) begin : g_full
            logic [BETA_W-1:0] beta;
            logic [PROD_W-1:0] prod;
            always_comb begin
                beta   = {head, {SHIFT_W{1'b0}}, {STATE_W{1'b1}}};
                prod   = {{STATE_W{1'b0}}, beta} * {{BETA_W{1'b0}}, k_cur};
                k_next = STATE_W'(prod >> STATE_W);
            end
        end else begin : g_reduced
            // Fraction of all ones contributes k-1 (k>0); integer part adds head*k shifted.
            logic [HEAD_W-1:0] mix;
            always_comb begin
                mix = head * k_cur[HEAD_W-1:0];
                if (k_cur == '0) begin
                    k_next = '0;
                end else begin
                    k_next = (k_cur - STATE_W'(1)) + {mix, {SHIFT_W{1'b0}}};
                end
            end
        end
    endgenerate

    // R4: the bits below the head field always follow k-1.
    always_comb begin
        if (!$isunknown(k_cur) && (k_cur != '0)) begin
            p_low_field_r4: assert (k_next[SHIFT_W-1:0] ==
                                    (k_cur[SHIFT_W-1:0] - SHIFT_W'(1)));
        end
    end

endmodule

// File: rtl/chaos_rng_top.sv
module chaos_rng_top
    import chaos_rng_pkg::*;
#(
    parameter int STATE_W      = 32,
    parameter bit FULL_PRODUCT = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               seed_load,
    input  logic [STATE_W-1:0] seed_val,
    input  logic               step_en,
    output logic               rnd_bit,
    output logic [STATE_W-1:0] state_out
);

    rng_fsm_e              fsm_q, fsm_d;
    logic [STATE_W-1:0]    k_q;
    logic [STATE_W-1:0]    k_step;
    logic [STATE_W-1:0]    seed_fixed;
    logic                  take_step;
    sel_code_t             code;
    beta_head_t            head;
    logic [CODE_REG_W-1:0] code_reg;

    // Next-state logic: UNSEEDED->RUN on load, RUN->RUN always.
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            ST_UNSEEDED: if (seed_load) fsm_d = ST_RUN;
            ST_RUN:      fsm_d = ST_RUN;
            default:     fsm_d = ST_UNSEEDED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) fsm_q <= ST_UNSEEDED;
        else     fsm_q <= fsm_d;
    end

    assign take_step  = (fsm_q == ST_RUN) && step_en && !seed_load;
    assign seed_fixed = (seed_val == '0) ? STATE_W'(1) : seed_val;

    chaos_code_lfsr u_code (
        .clk     (clk),
        .rst     (rst),
        .restart (seed_load),
        .advance (take_step),
        .code    (code),
        .reg_q   (code_reg)
    );

    chaos_head_dec u_dec (
        .code (code),
        .head (head)
    );

    chaos_map_step #(
        .STATE_W      (STATE_W),
        .FULL_PRODUCT (FULL_PRODUCT)
    ) u_step (
        .k_cur  (k_q),
        .head   (head),
        .k_next (k_step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            k_q <= '0;
        end else if (seed_load) begin
            k_q <= seed_fixed;
        end else if (take_step) begin
            k_q <= k_step;
        end
    end

    // Output process.
    always_comb begin
        state_out = k_q;
        rnd_bit   = k_q[STATE_W-1];
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (k_q == '0 && fsm_q == ST_UNSEEDED));

    p_unseeded_ignores_step_r2: assert property (@(posedge clk) disable iff (rst)
        (fsm_q == ST_UNSEEDED && !seed_load) |=> $stable(k_q));

    p_seed_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> (k_q != '0 && fsm_q == ST_RUN));

    p_pause_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (fsm_q == ST_RUN && !step_en && !seed_load) |=> ($stable(k_q) && $stable(code_reg)));

endmodule

// File: tb/tb_chaos_rng_top.sv
module tb_chaos_rng_top;

    localparam int WA = 32;
    localparam int WB = 12;

    logic          clk = 1'b0;
    logic          rst, seed_load, step_en;
    logic [WA-1:0] seed_val;
    logic          bit_a, bit_b;
    logic [WA-1:0] st_a;
    logic [WB-1:0] st_b;

    int n_checks = 0;
    int n_fail   = 0;

    logic [WA-1:0] m_a;
    logic [WB-1:0] m_b;
    logic [4:0]    m_lfsr;
    logic          m_run;

    always #10 clk = ~clk;

    chaos_rng_top #(.STATE_W(WA), .FULL_PRODUCT(1'b0)) dut (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_val(seed_val),
        .step_en(step_en), .rnd_bit(bit_a), .state_out(st_a));

    chaos_rng_top #(.STATE_W(WB), .FULL_PRODUCT(1'b1)) dut_b (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_val(seed_val[WB-1:0]),
        .step_en(step_en), .rnd_bit(bit_b), .state_out(st_b));

    function automatic logic [2:0] head_of(input logic [1:0] c);
        case (c)
            2'b00:   return 3'b111;
            2'b01:   return 3'b011;
            2'b10:   return 3'b110;
            default: return 3'b010;
        endcase
    endfunction

    // Reference map: floor(beta*k / 2^w) mod 2^w, computed with a wide product.
    function automatic logic [63:0] map_ref(input logic [63:0] k, input logic [1:0] c, input int w);
        logic [127:0] beta, prod, mask;
        mask = (128'(1) << w) - 128'(1);
        beta = (128'(head_of(c)) << (2*w - 3)) | mask;
        prod = beta * 128'(k);
        return 64'((prod >> w) & mask);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " state32"}, 64'(st_a), 64'(m_a));
        check({req, " state12"}, 64'(st_b), 64'(m_b));
        check("R7 bit32", 64'(bit_a), 64'(m_a[WA-1]));
        check("R7 bit12", 64'(bit_b), 64'(m_b[WB-1]));
    endtask

    // One cycle: drive at negedge, model the edge, compare at the next negedge.
    task automatic cyc(input logic ld, input logic [WA-1:0] sd, input logic en, input string req);
        logic [1:0] c;
        seed_load = ld; seed_val = sd; step_en = en; rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        c = m_lfsr[1:0];
        if (ld) begin
            m_a = (sd == '0) ? WA'(1) : sd;
            m_b = (sd[WB-1:0] == '0) ? WB'(1) : sd[WB-1:0];
            m_lfsr = 5'b00001;
            m_run = 1'b1;
        end else if (en && m_run) begin
            m_a = WA'(map_ref(64'(m_a), c, WA));
            m_b = WB'(map_ref(64'(m_b), c, WB));
            m_lfsr = {m_lfsr[3:0], m_lfsr[4] ^ m_lfsr[2]};
        end
        check_all(req);
    endtask

    task automatic do_reset();
        rst = 1'b1; seed_load = 1'b0; step_en = 1'b1; seed_val = '0;
        @(posedge clk);
        @(negedge clk);
        m_a = '0; m_b = '0; m_lfsr = 5'b00001; m_run = 1'b0;
        check_all("R1 reset");
    endtask

    initial begin
        #4000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [WA-1:0] first_a [0:39];
        void'($urandom(32'd20240611));
        rst = 1'b1; seed_load = 1'b0; step_en = 1'b0; seed_val = '0;
        @(negedge clk);
        do_reset();

        // R2: steps before any seed do nothing.
        for (int i = 0; i < 6; i++) cyc(1'b0, WA'($urandom), 1'b1, "R2 unseeded");

        // R3: zero seed stored as 1, then walk the map (R4/R5/R9).
        cyc(1'b1, '0, 1'b0, "R3 zero seed");
        for (int i = 0; i < 40; i++) cyc(1'b0, '0, 1'b1, "R4 step from one");

        // R3: load wins over step; reload restarts the code register so the stream repeats (R6).
        cyc(1'b1, 32'hDEAD_BEEF, 1'b1, "R3 load beats step");
        for (int i = 0; i < 40; i++) begin
            cyc(1'b0, '0, 1'b1, "R6 stream");
            first_a[i] = st_a;
        end
        cyc(1'b1, 32'hDEAD_BEEF, 1'b0, "R3 reload");
        for (int i = 0; i < 40; i++) begin
            cyc(1'b0, '0, 1'b1, "R6 repeat");
            check("R6 repeat matches", 64'(st_a), 64'(first_a[i]));
        end

        // R8: pause in the middle, then resume with the pending code.
        for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1, "R5 step");
        for (int i = 0; i < 7; i++) cyc(1'b0, WA'($urandom), 1'b0, "R8 pause");
        for (int i = 0; i < 5; i++) cyc(1'b0, '0, 1'b1, "R8 resume");

        // All-ones seed corner.
        cyc(1'b1, '1, 1'b0, "R3 ones seed");
        for (int i = 0; i < 70; i++) cyc(1'b0, '0, 1'b1, "R4 from ones");

        // Reset mid-run returns to UNSEEDED.
        do_reset();
        for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1, "R2 after reset");

        // Constrained random mix.
        for (int i = 0; i < 4000; i++) begin
            logic ld, en;
            logic [WA-1:0] sd;
            ld = ($urandom_range(0, 49) == 0);
            en = ($urandom_range(0, 3) != 0);
            sd = ($urandom_range(0, 5) == 0) ? '0 : WA'($urandom);
            cyc(ld, sd, en, "R9 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule